// File: doc/BRIEF.md
# Hazard-Aware Read/Write Batch Scheduler

This block sits in front of a DRAM command issuer. It collects read and write requests into batches, so that runs of reads and runs of writes reach the memory together and the data bus turns around less often. The batches form an ordered list held in a ring of batch slots. The newest slot collects writes and the slot before it collects reads. The list never holds fewer than two batches.

A read must never overtake an earlier write to the same bank and row. If an arriving read matches a queued write, the block does not move the read. It opens a fresh read/write batch pair behind the current one. Batches older than the newest pair drain strictly in list order. Within a batch, requests leave in arrival order.

The issuer sees one selected request at a time on the output. It pulses `done` to retire that request, and the next one is then presented.

Top module: `rw_batch_sched`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `out_valid` is 0 and `in_ready` is 1. This is the empty two-batch state.
- R2: A write always joins the newest (write) batch. With exactly two batches, queued reads are selected before queued writes.
- R3: Take a read with the same bank and the same row as a write in the current write batch. If the read batch is non-empty, or more than two batches exist, the read goes into a newly appended read batch. It is selected only after that write has retired.
- R4: A read that differs from every queued write in bank or in row joins the current read batch.
- R5: Take exactly two batches, an empty read batch and a non-empty write batch. An arriving read drops the empty front batch and appends a new pair, so all queued writes are selected before that read.
- R6: With more than two batches, the selected request always comes from the front batch. The front batch leaves the list as soon as its last request retires.
- R7: With exactly two batches that are both empty, `out_valid` is 0.
- R8: `in_ready` is 0, and the request is not taken, when appending a pair would make the list longer than `NUM_SLOTS` batches.
- R9: `in_ready` is 0, and the request is not taken, when its target batch already holds `DEPTH` requests.
- R10: An accepted request and a retirement in the same cycle both take effect. This includes a retirement that empties the old write batch while an R5 read reorganises the list.
- R11: Requests within one batch are selected in arrival order. While `out_valid` is 1 and `done` is 0, the selected request stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_is_write | input | 1 | 1 = write, 0 = read |
| in_bank | input | BANK_W | Bank of the request |
| in_row | input | ROW_W | Row of the request |
| in_tag | input | TAG_W | Caller's identifier, returned on output |
| out_valid | output | 1 | A request is selected |
| out_is_write | output | 1 | Direction of the selected request |
| out_bank | output | BANK_W | Bank of the selected request |
| out_row | output | ROW_W | Row of the selected request |
| out_tag | output | TAG_W | Identifier of the selected request |
| done | input | 1 | Retire the selected request (ignored when `out_valid` is 0) |

## Verification
Enqueue and retirement can land in the same cycle. They touch the list from opposite ends, and in the two-batch state they can hit the same slot.

The bench provokes three such collisions:
- a write added to the batch whose last request is leaving;
- a read added to a read batch while the front batch drains;
- an R5 read arriving in the cycle that retires the only queued write.

Each collision is judged by the request presented on the next cycle. A lost or duplicated reorganisation shows up as a wrong tag or a spurious idle.

// File: rtl/rwb_pkg.sv
// Shared types for the read/write batch scheduler.
package rwb_pkg;

    // How an accepted request changes the batch list.
    typedef enum logic [1:0] {
        ENQ_JOIN   = 2'd0,  // joins an existing batch
        ENQ_SPLIT  = 2'd1,  // hazard: append a new read/write pair
        ENQ_REOPEN = 2'd2   // drop empty front read batch, append pair
    } enq_kind_e;

endpackage

// File: rtl/rwb_slot_fifo.sv
// One batch slot: an in-order queue of requests.
// Also reports whether any queued entry matches a queried bank and row.
// Assumes clear and pop never arrive together. A cleared slot is always a
// freshly appended one, and such a slot is never the selected one.
module rwb_slot_fifo #(
    parameter int DEPTH  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 4,
    parameter int TAG_W  = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int EW = 1 + BANK_W + ROW_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [EW-1:0]     push_entry,
    input  logic              pop,
    output logic [EW-1:0]     head_entry,
    output logic [CW-1:0]     fill,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              row_hit
);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= push ? ptr_inc('0) : '0;
            fill   <= push ? CW'(1) : '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    // Entry storage. Data needs no reset; the fill count masks stale entries.
    always_ff @(posedge clk) begin
        if (push) begin
            if (clear) mem[0]      <= push_entry;
            else       mem[wr_ptr] <= push_entry;
        end
    end

    assign head_entry = mem[rd_ptr];

    // Compare the query against every live entry.
    always_comb begin
        row_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            int off;
            off = (i >= int'(rd_ptr)) ? i - int'(rd_ptr) : i + DEPTH - int'(rd_ptr);
            if (off < int'(fill) &&
                mem[i][EW-2 -: BANK_W] == q_bank &&
                mem[i][TAG_W + ROW_W - 1 -: ROW_W] == q_row)
                row_hit = 1'b1;
        end
    end

endmodule

// File: rtl/rwb_list_ctrl.sv
// Batch list controller.
// Tracks the front slot and the number of live batches in the slot ring.
// Decides where an incoming request goes and which slot supplies the output.
// Drops the front batch once it empties while more than two batches exist.
// Assumes NUM_SLOTS >= 4, so that a pair can be appended from two batches.
module rwb_list_ctrl
    import rwb_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DEPTH     = 4,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int NW = $clog2(NUM_SLOTS + 1),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_is_write,
    input  logic                 done,
    input  logic [CW-1:0]        fill [NUM_SLOTS],
    input  logic [NUM_SLOTS-1:0] hit,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [SW-1:0]        sel_slot,
    output logic [NUM_SLOTS-1:0] push_vec,
    output logic [NUM_SLOTS-1:0] clear_vec,
    output logic [NUM_SLOTS-1:0] pop_vec,
    output logic [NW-1:0]        batch_cnt,
    output logic [SW-1:0]        front_slot
);

    logic [SW-1:0] front_q;
    logic [NW-1:0] cnt_q;

    int        f_i, c_i;
    int        rd_s, wr_s, nrd_s, nwr_s, tgt_s, sel_s;
    int        rd_fill, wr_fill, need;
    int        f1, c1, front_d, cnt_d;
    int        fill_nx [NUM_SLOTS];
    logic      two, grow, accept, retire, drop;
    enq_kind_e kind;

    function automatic int wrap(input int base, input int off);
        return (base + off) % NUM_SLOTS;
    endfunction

    // Locate the current read/write batches and the slots of a new pair.
    always_comb begin
        f_i     = int'(front_q);
        c_i     = int'(cnt_q);
        rd_s    = wrap(f_i, c_i - 2);
        wr_s    = wrap(f_i, c_i - 1);
        nrd_s   = wrap(f_i, c_i);
        nwr_s   = wrap(f_i, c_i + 1);
        rd_fill = int'(fill[rd_s]);
        wr_fill = int'(fill[wr_s]);
        two     = (c_i == 2);
    end

    // Classify the offered request.
    always_comb begin
        kind = ENQ_JOIN;
        if (!in_is_write) begin
            if (!two)              kind = hit[wr_s] ? ENQ_SPLIT : ENQ_JOIN;
            else if (rd_fill != 0) kind = hit[wr_s] ? ENQ_SPLIT : ENQ_JOIN;
            else if (wr_fill != 0) kind = ENQ_REOPEN;
        end
    end

    // Target slot and admission.
    always_comb begin
        grow     = (kind != ENQ_JOIN);
        tgt_s    = grow ? nrd_s : (in_is_write ? wr_s : rd_s);
        need     = c_i + 2 - ((kind == ENQ_REOPEN) ? 1 : 0);
        in_ready = grow ? (need <= NUM_SLOTS) : (int'(fill[tgt_s]) < DEPTH);
        accept   = in_valid && in_ready;
    end

    // Output selection: the front batch when more than two exist, else reads first.
    always_comb begin
        out_valid = !two || rd_fill != 0 || wr_fill != 0;
        sel_s     = !two ? f_i : ((rd_fill != 0) ? rd_s : wr_s);
        retire    = done && out_valid;
    end

    // Per-slot strobes and the fill each slot will hold next cycle.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            push_vec[s]  = accept && (s == tgt_s);
            clear_vec[s] = accept && grow && (s == nrd_s || s == nwr_s);
            pop_vec[s]   = retire && (s == sel_s);
            if (clear_vec[s])
                fill_nx[s] = push_vec[s] ? 1 : 0;
            else
                fill_nx[s] = int'(fill[s]) + (push_vec[s] ? 1 : 0) - (pop_vec[s] ? 1 : 0);
        end
    end

    // Next list shape: growth, reopen, then removal of an emptied front.
    always_comb begin
        f1      = (accept && kind == ENQ_REOPEN) ? wrap(f_i, 1) : f_i;
        c1      = c_i + ((accept && grow) ? 2 : 0) - ((accept && kind == ENQ_REOPEN) ? 1 : 0);
        drop    = (c1 > 2) && (fill_nx[f1] == 0);
        front_d = drop ? wrap(f1, 1) : f1;
        cnt_d   = drop ? c1 - 1 : c1;
    end

    // List registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_q <= '0;
            cnt_q   <= NW'(2);
        end else begin
            front_q <= SW'(front_d);
            cnt_q   <= NW'(cnt_d);
        end
    end

    assign sel_slot   = SW'(sel_s);
    assign batch_cnt  = cnt_q;
    assign front_slot = front_q;

endmodule

// File: rtl/rw_batch_sched.sv
// Read/write batch scheduler top.
// Holds NUM_SLOTS batch queues in a ring and uses a list controller to
// order them. Presents one selected request; `done` retires it.
// Assumes the issuer raises `done` only for the request it sees on the output.
module rw_batch_sched #(
    parameter int NUM_SLOTS = 4,
    parameter int DEPTH     = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 4,
    parameter int TAG_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_write,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    output logic              out_is_write,
    output logic [BANK_W-1:0] out_bank,
    output logic [ROW_W-1:0]  out_row,
    output logic [TAG_W-1:0]  out_tag,
    input  logic              done
);

    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int NW = $clog2(NUM_SLOTS + 1);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = 1 + BANK_W + ROW_W + TAG_W;

    logic [EW-1:0]        in_entry;
    logic [EW-1:0]        head [NUM_SLOTS];
    logic [CW-1:0]        fill [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] push_vec, clear_vec, pop_vec;
    logic [SW-1:0]        sel_slot, front_slot;
    logic [NW-1:0]        batch_cnt;
    logic [CW-1:0]        front_fill;
    logic [EW-1:0]        out_entry;

    assign in_entry = {in_is_write, in_bank, in_row, in_tag};

    // One queue per batch slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        rwb_slot_fifo #(
            .DEPTH (DEPTH),
            .BANK_W(BANK_W),
            .ROW_W (ROW_W),
            .TAG_W (TAG_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear_vec[s]),
            .push      (push_vec[s]),
            .push_entry(in_entry),
            .pop       (pop_vec[s]),
            .head_entry(head[s]),
            .fill      (fill[s]),
            .q_bank    (in_bank),
            .q_row     (in_row),
            .row_hit   (hit[s])
        );
    end

    rwb_list_ctrl #(
        .NUM_SLOTS(NUM_SLOTS),
        .DEPTH    (DEPTH)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_is_write(in_is_write),
        .done       (done),
        .fill       (fill),
        .hit        (hit),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .sel_slot   (sel_slot),
        .push_vec   (push_vec),
        .clear_vec  (clear_vec),
        .pop_vec    (pop_vec),
        .batch_cnt  (batch_cnt),
        .front_slot (front_slot)
    );

    // Present the head of the selected slot.
    assign out_entry    = head[sel_slot];
    assign out_is_write = out_entry[EW-1];
    assign out_bank     = out_entry[EW-2 -: BANK_W];
    assign out_row      = out_entry[TAG_W + ROW_W - 1 -: ROW_W];
    assign out_tag      = out_entry[TAG_W-1:0];
    assign front_fill   = fill[front_slot];

endmodule

// File: rtl/rwb_sched_chk.sv
// Property checker for rw_batch_sched, attached by bind.
module rwb_sched_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int DEPTH     = 4,
    parameter int TAG_W     = 4,
    localparam int NW = $clog2(NUM_SLOTS + 1),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic             out_is_write,
    input logic             done,
    input logic [NW-1:0]    batch_cnt,
    input logic [CW-1:0]    front_fill
);

    // R1: reset leaves an idle, accepting scheduler.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    // R8: the list never exceeds the slot ring and never falls below two.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(batch_cnt) >= 2 && int'(batch_cnt) <= NUM_SLOTS));

    // R6: with more than two batches the front batch holds work.
    a_r6_front_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(batch_cnt) > 2) |-> (out_valid && front_fill != '0));

    // R9: no slot holds more than its depth.
    a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(front_fill) <= DEPTH);

    // R11: a selected request stays put until it is retired.
    a_r11_hold_until_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |=> (out_valid && $stable(out_tag) && $stable(out_is_write)));

endmodule

bind rw_batch_sched rwb_sched_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .DEPTH    (DEPTH),
    .TAG_W    (TAG_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_tag     (out_tag),
    .out_is_write(out_is_write),
    .done        (done),
    .batch_cnt   (batch_cnt),
    .front_fill  (front_fill)
);

// File: tb/test_rw_batch_sched.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module test_rw_batch_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_is_write = 1'b0;
    logic [1:0] in_bank = '0;
    logic [3:0] in_row = '0;
    logic [3:0] in_tag = '0;
    logic       out_valid;
    logic       out_is_write;
    logic [1:0] out_bank;
    logic [3:0] out_row;
    logic [3:0] out_tag;
    logic       done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rw_batch_sched #(
        .NUM_SLOTS(4), .DEPTH(4), .BANK_W(2), .ROW_W(4), .TAG_W(4)
    ) i_rw_batch_sched (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_write(in_is_write),
        .in_bank(in_bank), .in_row(in_row), .in_tag(in_tag),
        .out_valid(out_valid), .out_is_write(out_is_write),
        .out_bank(out_bank), .out_row(out_row), .out_tag(out_tag),
        .done(done)
    );

    typedef struct packed {
        logic       push;
        logic       wr;
        logic [1:0] bank;
        logic [3:0] row;
        logic [3:0] tag;
        logic       done;
        logic       rdy;   // expected in_ready before the edge
        logic       vld;   // expected out_valid after the edge
        logic [3:0] etag;  // expected out_tag after the edge
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,2'd0,4'd1, 4'd1, 1'b0,1'b1,1'b1,4'd1, 4'd2 },  // R2 write alone is selected
        '{1'b1,1'b0,2'd1,4'd2, 4'd2, 1'b0,1'b1,1'b1,4'd1, 4'd5 },  // R5 read behind queued write
        '{1'b1,1'b0,2'd0,4'd1, 4'd3, 1'b0,1'b1,1'b1,4'd1, 4'd6 },  // R6 front batch still served
        '{1'b1,1'b1,2'd2,4'd3, 4'd4, 1'b0,1'b1,1'b1,4'd1, 4'd2 },  // R2 write to newest batch
        '{1'b1,1'b0,2'd2,4'd3, 4'd5, 1'b0,1'b0,1'b1,4'd1, 4'd8 },  // R8 pair would overflow ring
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd2, 4'd6 },  // R6 emptied front dropped
        '{1'b1,1'b0,2'd2,4'd3, 4'd5, 1'b0,1'b1,1'b1,4'd2, 4'd3 },  // R3 hazard opens pair
        '{1'b1,1'b1,2'd2,4'd3, 4'd6, 1'b0,1'b1,1'b1,4'd2, 4'd2 },
        '{1'b1,1'b0,2'd3,4'd0, 4'd7, 1'b1,1'b1,1'b1,4'd3, 4'd10},  // R10 read join + retire
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd4, 4'd6 },
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd5, 4'd3 },  // R3 read after conflicting write
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd7, 4'd11},
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd6, 4'd6 },
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b0,4'd0, 4'd7 },  // R7 both empty
        '{1'b1,1'b0,2'd1,4'd5, 4'd8, 1'b0,1'b1,1'b1,4'd8, 4'd2 },
        '{1'b1,1'b1,2'd1,4'd6, 4'd9, 1'b0,1'b1,1'b1,4'd8, 4'd2 },
        '{1'b1,1'b0,2'd0,4'd6, 4'd10,1'b0,1'b1,1'b1,4'd8, 4'd4 },  // R4 other bank
        '{1'b1,1'b0,2'd1,4'd5, 4'd11,1'b0,1'b1,1'b1,4'd8, 4'd4 },  // R4 other row
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd10,4'd11},  // R11 arrival order
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd11,4'd11},
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b1,4'd9, 4'd2 },  // R2 reads before writes
        '{1'b1,1'b1,2'd0,4'd0, 4'd12,1'b1,1'b1,1'b1,4'd12,4'd10},  // R10 push+pop same slot
        '{1'b1,1'b0,2'd0,4'd0, 4'd13,1'b1,1'b1,1'b1,4'd13,4'd10},  // R10 reopen + retire
        '{1'b0,1'b0,2'd0,4'd0, 4'd0, 1'b1,1'b1,1'b0,4'd0, 4'd7 }
    };

    task automatic check(input string what, input int req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus; check ready before the edge, outputs after it.
    task automatic step(input logic push, input logic wr, input logic [1:0] bank,
                        input logic [3:0] row, input logic [3:0] tag, input logic dn,
                        input logic exp_rdy, input logic exp_vld, input logic [3:0] exp_tag,
                        input int req);
        @(negedge clk);
        in_valid = push; in_is_write = wr; in_bank = bank; in_row = row;
        in_tag = tag; done = dn;
        #1;
        if (push) check("in_ready", req, int'(in_ready), int'(exp_rdy));
        @(posedge clk);
        #1;
        check("out_valid", req, int'(out_valid), int'(exp_vld));
        if (exp_vld) check("out_tag", req, int'(out_tag), int'(exp_tag));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; done = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("reset out_valid", 1, int'(out_valid), 0);  // R1
        check("reset in_ready", 1, int'(in_ready), 1);    // R1
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int v = 0; v < NV; v++)
            step(VECS[v].push, VECS[v].wr, VECS[v].bank, VECS[v].row, VECS[v].tag,
                 VECS[v].done, VECS[v].rdy, VECS[v].vld, VECS[v].etag, int'(VECS[v].req));

        // R9: fill the write batch, then a fifth write is refused.
        do_reset();
        for (int k = 1; k <= 4; k++)
            step(1'b1, 1'b1, 2'd0, 4'(k), 4'(k), 1'b0, 1'b1, 1'b1, 4'd1, 9);
        step(1'b1, 1'b1, 2'd0, 4'd9, 4'd5, 1'b0, 1'b0, 1'b1, 4'd1, 9);
        // R11: drain in order, and the refused write never appears (R9).
        for (int k = 2; k <= 4; k++)
            step(1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b1, 4'(k), 11);
        step(1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 9);

        // R7: done with nothing selected leaves the block idle and accepting.
        step(1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 7);
        step(1'b1, 1'b0, 2'd1, 4'd1, 4'd7, 1'b0, 1'b1, 1'b1, 4'd7, 7);

        // R1: reset in mid-stream empties the scheduler.
        step(1'b1, 1'b1, 2'd1, 4'd1, 4'd8, 1'b0, 1'b1, 1'b1, 4'd7, 2);
        do_reset();
        step(1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0, 1);

        @(negedge clk);
        in_valid = 1'b0; done = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule